// File: doc/BRIEF.md
# Early Branch Check and Squash Unit

This unit sits between instruction fetch and the rename stage of one thread. Each cycle it accepts a group of up to WIDTH instructions in program order. Every instruction carries its sequence number, PC, predicted next PC, a predicted-taken flag, control-type flags, a direct target and a source-register count. The unit drops instructions that are already squashed and packs the survivors into consecutive output slots. It tags instructions with no source operands as ready to issue. It resolves direct unconditional control transfers on the spot by replacing their next PC with the encoded target.

The unit also checks two kinds of wrong prediction. The first is a resolved direct branch whose target disagrees with the predicted next PC. The second is an instruction predicted taken that is not a control instruction at all. The first such offender in a group is still forwarded, with its corrected next PC. Every younger instruction of the group, judged by a larger sequence number, is discarded as squashed. A registered redirect record then tells fetch where to restart. Five event counters track resolved branches, branch mispredicts, control mispredicts, forwarded instructions and dropped squashed instructions.

Top module: `ebc_unit`

## Requirements
- R1: Lanes hold instructions in ascending sequence order. The kept instructions of a group appear one cycle later in output slots 0 upward, with no gaps and in lane order. Lanes with inValid low are ignored.
- R2: A valid lane whose inSquashed bit is set occupies no output slot, and it adds one to cntDrop.
- R3: outReady of a slot is 1 exactly when that instruction's source-register count is zero.
- R4: A forwarded instruction with both inIsDirect and inIsUncond set leaves with outNextPc equal to its inTarget. Any other non-offending instruction leaves with its predicted next PC.
- R5: A direct unconditional instruction whose target differs from its predicted next PC is a branch mispredict. It is forwarded, and no later lane of the group is forwarded.
- R6: An instruction with inPredTaken set and inIsCtrl clear is a control mispredict. It is forwarded with outNextPc equal to its PC plus ISIZE, and no later lane of the group is forwarded.
- R7: In the cycle after a mispredict, rdSquash, rdMispredict and rdPredWrong are all 1. In that same cycle rdSeq is the offender's sequence number and rdNextPc is its corrected next PC. rdTaken is 1 when rdNextPc differs from the offender's PC plus ISIZE. In every cycle after a group with no mispredict, all three flags are 0.
- R8: Only the first offender of a group acts. A valid lane after it whose sequence number is larger than the offender's is dropped and counted in cntDrop.
- R9: cntResolved grows by the number of forwarded direct unconditional instructions. cntBrMisp and cntCtrlMisp each grow by one per event of their kind. cntFwd grows by the number of filled output slots. All counters change in the same cycle as the outputs.
- R10: While reset is high, all output slots, redirect flags and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | WIDTH | Lane holds an instruction |
| inSquashed | input | WIDTH | Instruction already squashed |
| inSeq | input | WIDTH x SEQW | Sequence number per lane |
| inPc | input | WIDTH x PCW | PC per lane |
| inPredTaken | input | WIDTH | Predicted taken |
| inPredNpc | input | WIDTH x PCW | Predicted next PC |
| inIsCtrl | input | WIDTH | Control instruction |
| inIsDirect | input | WIDTH | Target encoded in the instruction |
| inIsUncond | input | WIDTH | Unconditional transfer |
| inTarget | input | WIDTH x PCW | Direct target |
| inNumSrc | input | WIDTH x SRCW | Source-register count |
| outValid | output | WIDTH | Slot filled |
| outSeq | output | WIDTH x SEQW | Sequence number per slot |
| outPc | output | WIDTH x PCW | PC per slot |
| outNextPc | output | WIDTH x PCW | Resolved next PC per slot |
| outReady | output | WIDTH | Ready to issue (no sources) |
| rdSquash | output | 1 | Redirect: squash |
| rdMispredict | output | 1 | Redirect: mispredict |
| rdPredWrong | output | 1 | Redirect: prediction incorrect |
| rdSeq | output | SEQW | Redirect: offender sequence number |
| rdNextPc | output | PCW | Redirect: corrected next PC |
| rdTaken | output | 1 | Redirect: corrected path is non-sequential |
| cntResolved | output | CNTW | Direct unconditional branches resolved |
| cntBrMisp | output | CNTW | Branch mispredicts |
| cntCtrlMisp | output | CNTW | Control mispredicts |
| cntFwd | output | CNTW | Instructions forwarded |
| cntDrop | output | CNTW | Squashed instructions dropped |

## Verification
The dropping of instructions that arrive already squashed can fall in the same cycle as a mispredict. In that cycle cntDrop takes both kinds of drop together, and the slot packing must skip both. Directed groups put a pre-squashed lane before an offender and younger lanes after it. The random groups mix squashed bits with both mispredict kinds at random positions. A bench model computes the expected slot contents, the redirect record and all counter values from the requirements. Every cycle, the slots, the redirect record and the counters are compared against that model.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic fire;     // a mispredict was found in this group
    logic brMiss;   // offender is a wrong direct unconditional branch
    logic ctlMiss;  // offender is a non-control predicted taken
  } ebcStrobe_t;
endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SEQW  = 16,
  parameter int PCW   = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIDTH-1:0]           inValid,
  input  logic [WIDTH-1:0]           inSquashed,
  input  logic [WIDTH-1:0][SEQW-1:0] inSeq,
  input  logic [WIDTH-1:0]           inPredTaken,
  input  logic [WIDTH-1:0][PCW-1:0]  inPredNpc,
  input  logic [WIDTH-1:0]           inIsCtrl,
  input  logic [WIDTH-1:0]           inIsDirect,
  input  logic [WIDTH-1:0]           inIsUncond,
  input  logic [WIDTH-1:0][PCW-1:0]  inTarget,
  output logic [WIDTH-1:0]           keepLane,
  output logic [WIDTH-1:0]           dropLane,
  output logic [WIDTH-1:0]           resolveLane,
  output logic [WIDTH-1:0]           offLane,
  output ebcStrobe_t                 strobe
);
  logic            found;
  logic [SEQW-1:0] offSeq;

  always_comb begin
    found       = 1'b0;
    offSeq      = '0;
    keepLane    = '0;
    dropLane    = '0;
    resolveLane = '0;
    offLane     = '0;
    strobe      = '0;
    for (int i = 0; i < WIDTH; i++) begin
      logic isRes, brM, ctM;
      isRes = inIsDirect[i] & inIsUncond[i];
      brM   = isRes & (inTarget[i] != inPredNpc[i]);
      ctM   = inPredTaken[i] & ~inIsCtrl[i];
      if (inValid[i]) begin
        if (found) begin
          if (inSeq[i] > offSeq) dropLane[i] = 1'b1;
        end else if (inSquashed[i]) begin
          dropLane[i] = 1'b1;
        end else begin
          keepLane[i]    = 1'b1;
          resolveLane[i] = isRes;
          if (brM | ctM) begin
            found          = 1'b1;
            offSeq         = inSeq[i];
            offLane[i]     = 1'b1;
            strobe.fire    = 1'b1;
            strobe.brMiss  = brM;
            strobe.ctlMiss = ctM;
          end
        end
      end
    end
  end

  // R8: at most one offender per group
  a_r8_single_offender: assert property (@(posedge clk) disable iff (rst)
    $onehot0(offLane));
  // R5: the offender itself is forwarded
  a_r5_offender_kept: assert property (@(posedge clk) disable iff (rst)
    (offLane & ~keepLane) == '0);
  // R2: a lane is never both forwarded and dropped
  a_r2_keep_drop_disjoint: assert property (@(posedge clk) disable iff (rst)
    (keepLane & dropLane) == '0);
  // R7: a fire strobe always comes with exactly one offender lane
  a_r7_fire_has_lane: assert property (@(posedge clk) disable iff (rst)
    strobe.fire |-> ($countones(offLane) == 1));
endmodule

// File: rtl/ebc_dpath.sv
module ebc_dpath
  import ebc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SEQW  = 16,
  parameter int PCW   = 32,
  parameter int SRCW  = 3,
  parameter int ISIZE = 4,
  parameter int CNTW  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIDTH-1:0][SEQW-1:0] inSeq,
  input  logic [WIDTH-1:0][PCW-1:0]  inPc,
  input  logic [WIDTH-1:0]           inPredTaken,
  input  logic [WIDTH-1:0][PCW-1:0]  inPredNpc,
  input  logic [WIDTH-1:0]           inIsCtrl,
  input  logic [WIDTH-1:0]           inIsDirect,
  input  logic [WIDTH-1:0]           inIsUncond,
  input  logic [WIDTH-1:0][PCW-1:0]  inTarget,
  input  logic [WIDTH-1:0][SRCW-1:0] inNumSrc,
  input  logic [WIDTH-1:0]           keepLane,
  input  logic [WIDTH-1:0]           dropLane,
  input  logic [WIDTH-1:0]           resolveLane,
  input  logic [WIDTH-1:0]           offLane,
  input  ebcStrobe_t                 strobe,
  output logic [WIDTH-1:0]           outValid,
  output logic [WIDTH-1:0][SEQW-1:0] outSeq,
  output logic [WIDTH-1:0][PCW-1:0]  outPc,
  output logic [WIDTH-1:0][PCW-1:0]  outNextPc,
  output logic [WIDTH-1:0]           outReady,
  output logic                       rdSquash,
  output logic                       rdMispredict,
  output logic                       rdPredWrong,
  output logic [SEQW-1:0]            rdSeq,
  output logic [PCW-1:0]             rdNextPc,
  output logic                       rdTaken,
  output logic [CNTW-1:0]            cntResolved,
  output logic [CNTW-1:0]            cntBrMisp,
  output logic [CNTW-1:0]            cntCtrlMisp,
  output logic [CNTW-1:0]            cntFwd,
  output logic [CNTW-1:0]            cntDrop
);
  localparam int IDXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PCW-1:0] STEP = PCW'(ISIZE);

  function automatic logic [CNTW-1:0] popCnt(input logic [WIDTH-1:0] v);
    logic [CNTW-1:0] n;
    n = '0;
    for (int i = 0; i < WIDTH; i++) n = n + CNTW'(v[i]);
    return n;
  endfunction

  // Per-lane resolved next PC and sequential PC
  logic [WIDTH-1:0][PCW-1:0] laneNpc, laneSeqPc;
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign laneSeqPc[g] = inPc[g] + STEP;
    assign laneNpc[g]   = (inIsDirect[g] & inIsUncond[g]) ? inTarget[g] :
                          (inPredTaken[g] & ~inIsCtrl[g]) ? laneSeqPc[g] :
                          inPredNpc[g];
  end

  // Pack kept lanes into consecutive slots
  logic [WIDTH-1:0]           nxtValid, nxtReady;
  logic [WIDTH-1:0][SEQW-1:0] nxtSeq;
  logic [WIDTH-1:0][PCW-1:0]  nxtPc, nxtNpc;
  logic [IDXW:0]              slot;

  always_comb begin
    nxtValid = '0;
    nxtReady = '0;
    nxtSeq   = '0;
    nxtPc    = '0;
    nxtNpc   = '0;
    slot     = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (keepLane[i]) begin
        nxtValid[slot[IDXW-1:0]] = 1'b1;
        nxtReady[slot[IDXW-1:0]] = (inNumSrc[i] == '0);
        nxtSeq[slot[IDXW-1:0]]   = inSeq[i];
        nxtPc[slot[IDXW-1:0]]    = inPc[i];
        nxtNpc[slot[IDXW-1:0]]   = laneNpc[i];
        slot = slot + 1'b1;
      end
    end
  end

  // Select offender fields from the one-hot lane mask
  logic [SEQW-1:0] offSeqSel;
  logic [PCW-1:0]  offNpcSel, offSeqPcSel;
  always_comb begin
    offSeqSel   = '0;
    offNpcSel   = '0;
    offSeqPcSel = '0;
    for (int i = 0; i < WIDTH; i++) begin
      offSeqSel   = offSeqSel   | ({SEQW{offLane[i]}} & inSeq[i]);
      offNpcSel   = offNpcSel   | ({PCW{offLane[i]}}  & laneNpc[i]);
      offSeqPcSel = offSeqPcSel | ({PCW{offLane[i]}}  & laneSeqPc[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid     <= '0;
      outReady     <= '0;
      outSeq       <= '0;
      outPc        <= '0;
      outNextPc    <= '0;
      rdSquash     <= 1'b0;
      rdMispredict <= 1'b0;
      rdPredWrong  <= 1'b0;
      rdSeq        <= '0;
      rdNextPc     <= '0;
      rdTaken      <= 1'b0;
      cntResolved  <= '0;
      cntBrMisp    <= '0;
      cntCtrlMisp  <= '0;
      cntFwd       <= '0;
      cntDrop      <= '0;
    end else begin
      outValid     <= nxtValid;
      outReady     <= nxtReady;
      outSeq       <= nxtSeq;
      outPc        <= nxtPc;
      outNextPc    <= nxtNpc;
      rdSquash     <= strobe.fire;
      rdMispredict <= strobe.fire;
      rdPredWrong  <= strobe.fire;
      rdSeq        <= strobe.fire ? offSeqSel : '0;
      rdNextPc     <= strobe.fire ? offNpcSel : '0;
      rdTaken      <= strobe.fire & (offNpcSel != offSeqPcSel);
      cntResolved  <= cntResolved + popCnt(resolveLane);
      cntBrMisp    <= cntBrMisp + CNTW'(strobe.brMiss);
      cntCtrlMisp  <= cntCtrlMisp + CNTW'(strobe.ctlMiss);
      cntFwd       <= cntFwd + popCnt(keepLane);
      cntDrop      <= cntDrop + popCnt(dropLane);
    end
  end

  // R1: filled slots form a contiguous run from slot 0
  a_r1_compact: assert property (@(posedge clk) disable iff (rst)
    (outValid & (outValid + 1'b1)) == '0);
  // R7: the three redirect flags travel together
  a_r7_flags_agree: assert property (@(posedge clk) disable iff (rst)
    (rdSquash == rdMispredict) && (rdSquash == rdPredWrong));
  // R9: forwarded count tracks the filled output slots
  a_r9_fwd_tracks_slots: assert property (@(posedge clk) disable iff (rst)
    cntFwd == $past(cntFwd) + popCnt(outValid));
  // R9: a redirect cycle bumps exactly one or both mispredict counters
  a_r9_misp_counted: assert property (@(posedge clk) disable iff (rst)
    rdSquash |-> ((cntBrMisp + cntCtrlMisp) != ($past(cntBrMisp) + $past(cntCtrlMisp))));
endmodule

// File: rtl/ebc_unit.sv
module ebc_unit
  import ebc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SEQW  = 16,
  parameter int PCW   = 32,
  parameter int SRCW  = 3,
  parameter int ISIZE = 4,
  parameter int CNTW  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIDTH-1:0]           inValid,
  input  logic [WIDTH-1:0]           inSquashed,
  input  logic [WIDTH-1:0][SEQW-1:0] inSeq,
  input  logic [WIDTH-1:0][PCW-1:0]  inPc,
  input  logic [WIDTH-1:0]           inPredTaken,
  input  logic [WIDTH-1:0][PCW-1:0]  inPredNpc,
  input  logic [WIDTH-1:0]           inIsCtrl,
  input  logic [WIDTH-1:0]           inIsDirect,
  input  logic [WIDTH-1:0]           inIsUncond,
  input  logic [WIDTH-1:0][PCW-1:0]  inTarget,
  input  logic [WIDTH-1:0][SRCW-1:0] inNumSrc,
  output logic [WIDTH-1:0]           outValid,
  output logic [WIDTH-1:0][SEQW-1:0] outSeq,
  output logic [WIDTH-1:0][PCW-1:0]  outPc,
  output logic [WIDTH-1:0][PCW-1:0]  outNextPc,
  output logic [WIDTH-1:0]           outReady,
  output logic                       rdSquash,
  output logic                       rdMispredict,
  output logic                       rdPredWrong,
  output logic [SEQW-1:0]            rdSeq,
  output logic [PCW-1:0]             rdNextPc,
  output logic                       rdTaken,
  output logic [CNTW-1:0]            cntResolved,
  output logic [CNTW-1:0]            cntBrMisp,
  output logic [CNTW-1:0]            cntCtrlMisp,
  output logic [CNTW-1:0]            cntFwd,
  output logic [CNTW-1:0]            cntDrop
);
  logic [WIDTH-1:0] keepLane, dropLane, resolveLane, offLane;
  ebcStrobe_t       strobe;

  ebc_ctrl #(.WIDTH(WIDTH), .SEQW(SEQW), .PCW(PCW)) u_ctrl (
    .clk(clk), .rst(rst),
    .inValid(inValid), .inSquashed(inSquashed), .inSeq(inSeq),
    .inPredTaken(inPredTaken), .inPredNpc(inPredNpc), .inIsCtrl(inIsCtrl),
    .inIsDirect(inIsDirect), .inIsUncond(inIsUncond), .inTarget(inTarget),
    .keepLane(keepLane), .dropLane(dropLane), .resolveLane(resolveLane),
    .offLane(offLane), .strobe(strobe)
  );

  ebc_dpath #(.WIDTH(WIDTH), .SEQW(SEQW), .PCW(PCW), .SRCW(SRCW),
              .ISIZE(ISIZE), .CNTW(CNTW)) u_dpath (
    .clk(clk), .rst(rst),
    .inSeq(inSeq), .inPc(inPc), .inPredTaken(inPredTaken), .inPredNpc(inPredNpc),
    .inIsCtrl(inIsCtrl), .inIsDirect(inIsDirect), .inIsUncond(inIsUncond),
    .inTarget(inTarget), .inNumSrc(inNumSrc),
    .keepLane(keepLane), .dropLane(dropLane), .resolveLane(resolveLane),
    .offLane(offLane), .strobe(strobe),
    .outValid(outValid), .outSeq(outSeq), .outPc(outPc), .outNextPc(outNextPc),
    .outReady(outReady), .rdSquash(rdSquash), .rdMispredict(rdMispredict),
    .rdPredWrong(rdPredWrong), .rdSeq(rdSeq), .rdNextPc(rdNextPc), .rdTaken(rdTaken),
    .cntResolved(cntResolved), .cntBrMisp(cntBrMisp), .cntCtrlMisp(cntCtrlMisp),
    .cntFwd(cntFwd), .cntDrop(cntDrop)
  );
endmodule

// File: tb/ebc_unit_bench.sv
module ebc_unit_bench;
  localparam int W = 4, SEQW = 16, PCW = 32, SRCW = 3, ISZ = 4, CNTW = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] vld, sq, pt, ctl, dir, unc;
  logic [W-1:0][SEQW-1:0] seq;
  logic [W-1:0][PCW-1:0]  pc, pnpc, tgt;
  logic [W-1:0][SRCW-1:0] nsrc;

  logic [W-1:0] oValid, oReady;
  logic [W-1:0][SEQW-1:0] oSeq;
  logic [W-1:0][PCW-1:0]  oPc, oNpc;
  logic rSq, rMis, rPw, rTk;
  logic [SEQW-1:0] rSeq;
  logic [PCW-1:0]  rNpc;
  logic [CNTW-1:0] cRes, cBm, cCm, cFwd, cDrop;

  ebc_unit #(.WIDTH(W), .SEQW(SEQW), .PCW(PCW), .SRCW(SRCW), .ISIZE(ISZ), .CNTW(CNTW)) u_ebc_unit (
    .clk(clk), .rst(rst), .inValid(vld), .inSquashed(sq), .inSeq(seq), .inPc(pc),
    .inPredTaken(pt), .inPredNpc(pnpc), .inIsCtrl(ctl), .inIsDirect(dir),
    .inIsUncond(unc), .inTarget(tgt), .inNumSrc(nsrc),
    .outValid(oValid), .outSeq(oSeq), .outPc(oPc), .outNextPc(oNpc), .outReady(oReady),
    .rdSquash(rSq), .rdMispredict(rMis), .rdPredWrong(rPw), .rdSeq(rSeq),
    .rdNextPc(rNpc), .rdTaken(rTk), .cntResolved(cRes), .cntBrMisp(cBm),
    .cntCtrlMisp(cCm), .cntFwd(cFwd), .cntDrop(cDrop));

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // expected state
  logic [W-1:0] eValid, eReady;
  logic [W-1:0][SEQW-1:0] eSeq;
  logic [W-1:0][PCW-1:0]  ePc, eNpc;
  logic eSq, eTk;
  logic [SEQW-1:0] eRSeq;
  logic [PCW-1:0]  eRNpc;
  logic [CNTW-1:0] mRes = 0, mBm = 0, mCm = 0, mFwd = 0, mDrop = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearLanes();
    vld = '0; sq = '0; pt = '0; ctl = '0; dir = '0; unc = '0;
    seq = '0; pc = '0; pnpc = '0; tgt = '0; nsrc = '0;
  endtask

  task automatic setLane(input int i, input bit s, input logic [SEQW-1:0] sn,
                         input logic [PCW-1:0] p, input bit ptk, input logic [PCW-1:0] pn,
                         input bit c, input bit d, input bit u,
                         input logic [PCW-1:0] t, input logic [SRCW-1:0] ns);
    vld[i] = 1'b1; sq[i] = s; seq[i] = sn; pc[i] = p; pt[i] = ptk; pnpc[i] = pn;
    ctl[i] = c; dir[i] = d; unc[i] = u; tgt[i] = t; nsrc[i] = ns;
  endtask

  // Reference model built from the requirements
  task automatic model();
    bit found = 0;
    logic [SEQW-1:0] offS = '0;
    int k = 0;
    eValid = '0; eReady = '0; eSeq = '0; ePc = '0; eNpc = '0;
    eSq = 0; eTk = 0; eRSeq = '0; eRNpc = '0;
    for (int i = 0; i < W; i++) begin
      logic [PCW-1:0] np;
      bit bm, cm, res;
      if (!vld[i]) continue;
      if (found) begin
        if (seq[i] > offS) mDrop++;
        continue;
      end
      if (sq[i]) begin mDrop++; continue; end
      res = dir[i] && unc[i];
      bm  = res && (tgt[i] != pnpc[i]);
      cm  = pt[i] && !ctl[i];
      np  = res ? tgt[i] : (cm ? pc[i] + ISZ : pnpc[i]);
      eValid[k] = 1; eSeq[k] = seq[i]; ePc[k] = pc[i]; eNpc[k] = np;
      eReady[k] = (nsrc[i] == 0);
      k++; mFwd++;
      if (res) mRes++;
      if (bm || cm) begin
        found = 1; offS = seq[i];
        eSq = 1; eRSeq = seq[i]; eRNpc = np; eTk = (np != pc[i] + ISZ);
        if (bm) mBm++;
        if (cm) mCm++;
      end
    end
  endtask

  task automatic compare(input string tag);
    chk(oValid == eValid, tag, "R1 slot valid", oValid, eValid);
    for (int s = 0; s < W; s++) if (eValid[s]) begin
      chk(oSeq[s] == eSeq[s] && oPc[s] == ePc[s], tag, "R1 slot seq/pc", {oSeq[s], oPc[s]}, {eSeq[s], ePc[s]});
      chk(oNpc[s] == eNpc[s], tag, "R4 next pc", oNpc[s], eNpc[s]);
      chk(oReady[s] == eReady[s], tag, "R3 ready", oReady[s], eReady[s]);
    end
    chk(rSq == eSq && rMis == eSq && rPw == eSq, tag, "R7 redirect flags", {rSq, rMis, rPw}, {3{eSq}});
    if (eSq) begin
      chk(rSeq == eRSeq, tag, "R7 redirect seq", rSeq, eRSeq);
      chk(rNpc == eRNpc, tag, "R7 redirect pc", rNpc, eRNpc);
      chk(rTk == eTk, tag, "R7 redirect taken", rTk, eTk);
    end
    chk(cRes == mRes, tag, "R9 resolved", cRes, mRes);
    chk(cBm == mBm && cCm == mCm, tag, "R9 mispredict counts", {cBm, cCm}, {mBm, mCm});
    chk(cFwd == mFwd, tag, "R9 forwarded", cFwd, mFwd);
    chk(cDrop == mDrop, tag, "R2 R8 dropped", cDrop, mDrop);
  endtask

  // Inputs are set at a negedge; outputs checked at the next negedge
  task automatic runGroup(input string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [SEQW-1:0] sn;
    logic [PCW-1:0] p;
    void'($urandom(32'd4242));
    clearLanes();
    setLane(0, 0, 16'd1, 32'h100, 1, 32'h200, 0, 0, 0, 32'h0, 3'd1); // would mispredict
    repeat (3) @(negedge clk);
    // R10: reset holds everything at zero even with live inputs
    chk(oValid == '0 && oReady == '0, "R10", "reset slots", oValid, 0);
    chk({rSq, rMis, rPw, rTk} == '0, "R10", "reset redirect", {rSq, rMis, rPw, rTk}, 0);
    chk((cRes | cBm | cCm | cFwd | cDrop) == '0, "R10", "reset counters", cFwd, 0);
    rst = 1'b0;
    clearLanes();
    runGroup("R10");

    // plain group, mixed source counts
    clearLanes();
    for (int i = 0; i < W; i++) setLane(i, 0, 16'(10 + i), 32'(32'h1000 + 4 * i), 0, 32'(32'h1004 + 4 * i), 0, 0, 0, 0, 3'(i % 2 * 2));
    runGroup("R1 R3");

    // pre-squashed lanes 1 and 3
    clearLanes();
    for (int i = 0; i < W; i++) setLane(i, (i % 2) == 1, 16'(20 + i), 32'(32'h2000 + 4 * i), 0, 32'(32'h2004 + 4 * i), 0, 0, 0, 0, 3'd1);
    runGroup("R2");

    // correct direct branch in lane 1: resolved, no redirect
    clearLanes();
    setLane(0, 0, 16'd30, 32'h3000, 0, 32'h3004, 0, 0, 0, 0, 3'd2);
    setLane(1, 0, 16'd31, 32'h3004, 1, 32'h3800, 1, 1, 1, 32'h3800, 3'd0);
    runGroup("R4");

    // wrong direct branch in lane 1: younger lanes dropped
    clearLanes();
    setLane(0, 0, 16'd40, 32'h4000, 0, 32'h4004, 0, 0, 0, 0, 3'd1);
    setLane(1, 0, 16'd41, 32'h4004, 0, 32'h4008, 1, 1, 1, 32'h4400, 3'd0);
    setLane(2, 0, 16'd42, 32'h4008, 0, 32'h400c, 0, 0, 0, 0, 3'd1);
    setLane(3, 0, 16'd43, 32'h400c, 0, 32'h4010, 0, 0, 0, 0, 3'd1);
    runGroup("R5 R8");

    // control mispredict in lane 2 with a squashed lane 0 in the same group
    clearLanes();
    setLane(0, 1, 16'd50, 32'h5000, 0, 32'h5004, 0, 0, 0, 0, 3'd1);
    setLane(1, 0, 16'd51, 32'h5004, 0, 32'h5008, 0, 0, 0, 0, 3'd1);
    setLane(2, 0, 16'd52, 32'h5008, 1, 32'h5800, 0, 0, 0, 0, 3'd2);
    setLane(3, 0, 16'd53, 32'h500c, 0, 32'h5010, 0, 0, 0, 0, 3'd1);
    runGroup("R6 R2");

    // two offenders: only the first acts; branch target sequential so taken=0
    clearLanes();
    setLane(0, 0, 16'd60, 32'h6000, 1, 32'h6800, 1, 1, 1, 32'h6004, 3'd0);
    setLane(1, 0, 16'd61, 32'h6004, 1, 32'h6900, 0, 0, 0, 0, 3'd1);
    setLane(2, 0, 16'd62, 32'h6008, 0, 32'h600c, 0, 0, 0, 0, 3'd1);
    runGroup("R8 R7");

    // back-to-back redirects then an idle group with a gap lane
    clearLanes();
    setLane(3, 0, 16'd70, 32'h7000, 1, 32'h7100, 0, 0, 0, 0, 3'd1);
    runGroup("R7 R6");
    clearLanes();
    setLane(0, 0, 16'd80, 32'h8000, 0, 32'h8004, 1, 1, 1, 32'h8080, 3'd0);
    runGroup("R7 R5");
    clearLanes();
    setLane(0, 0, 16'd90, 32'h9000, 0, 32'h9004, 0, 0, 0, 0, 3'd0);
    setLane(2, 0, 16'd91, 32'h9004, 0, 32'h9008, 0, 0, 0, 0, 3'd1);
    runGroup("R1 R7");

    // random groups
    sn = 16'd100; p = 32'h10000;
    for (int n = 0; n < 400; n++) begin
      clearLanes();
      for (int i = 0; i < W; i++) begin
        int r;
        logic [PCW-1:0] t;
        r = int'($urandom_range(0, 99));
        if ($urandom_range(0, 99) < 85) begin
          t = p + 4 * $urandom_range(0, 3) * ISZ;
          if (r < 25)
            setLane(i, $urandom_range(0, 4) == 0, sn, p, 1, ($urandom_range(0, 1) != 0) ? t : p + 64,
                    1, 1, 1, t, 3'($urandom_range(0, 2)));
          else if (r < 35)
            setLane(i, $urandom_range(0, 4) == 0, sn, p, 1, p + 128, 0, 0, 0, 0, 3'($urandom_range(0, 2)));
          else
            setLane(i, $urandom_range(0, 4) == 0, sn, p, 0, p + ISZ, r < 45, 0, 0, 0, 3'($urandom_range(0, 2)));
        end
        sn = sn + 1'b1; p = p + ISZ;
      end
      runGroup("R1 R2 R4 R8 R9 random");
    end
    clearLanes();
    runGroup("R7 R9 idle");
    finish();
  end
endmodule